// File: doc/BRIEF.md
# Bit-Flipping Decoder for Two-Block Quasi-Cyclic Moderate-Density Parity-Check Codes

This block recovers the plaintext half of a ciphertext built from two circulant blocks, x = [x0|x1], each R bits wide, using a secret parity-check row h = [h0|h1]. A start strobe captures the key halves and the ciphertext from parallel input ports. The block first builds the syndrome by walking all R positions of x0 and x1 together while the key halves rotate one place per step. It then checks the syndrome against zero. While the syndrome is nonzero it runs bit-flipping passes. Each pass compares unsatisfied-check counts against a threshold fixed for that pass. Whenever a codeword bit flips, the matching key row is folded straight into the syndrome.

The syndrome is never rebuilt after the first pass. Its zero test uses a two-stage registered OR tree. The counts come from two registered popcount pipelines, one per key half. Each position waits for its counts, so it is always judged against a syndrome that already holds every earlier flip. The block ends with a one-cycle done pulse. On success it reports ok and x0. If the syndrome is still nonzero after the last allowed pass, it reports failure instead.

Top module: `qcmdpc_bitflip_dec`

## Requirements
- R1: After reset, done_o and ok_o are low and pt_o is all zeros.
- R2: The syndrome is the polynomial sum x0·h0 + x1·h1 modulo z^R − 1. Bit k of the key row used at position j is h[(k − j) mod R]. A valid codeword, such as x0 = h1 with x1 = h0, therefore decodes with ok_o = 1 and pt_o equal to x0 unchanged.
- R3: The zero test runs right after the syndrome pass. A zero syndrome ends decoding with success and no flipping pass, so an all-zero ciphertext returns pt_o = 0.
- R4: At each position j, two counts are taken from the same syndrome: c0 = weight(s AND row0_j) and c1 = weight(s AND row1_j). A bit of x0 (or x1) flips only when c0 (or c1) is strictly greater than the threshold of the current pass. The row of each flipped bit is XORed into the syndrome before position j+1 is evaluated.
- R5: Thresholds are a packed parameter with TW bits per pass, and pass 1 sits in the least significant field. The default for R = 24 is 3, 3, 2, 2, 2 for passes 1 to 5.
- R6: If the syndrome is nonzero at the end of pass MAX_ITER (default 5), done_o pulses with ok_o = 0 and pt_o equal to the current x0. The syndrome is tested only between passes.
- R7: done_o is high for exactly one cycle, and ok_o and pt_o are valid while it is high.
- R8: A start pulse that arrives while a decode is in progress has no effect on that decode's result.
- R9: done_o rises R + 3 cycles after the edge that accepts start, plus 3R + 3 cycles for every flipping pass run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture inputs and begin decoding (idle only) |
| h0_i | input | R | First secret key half |
| h1_i | input | R | Second secret key half |
| x0_i | input | R | First ciphertext half |
| x1_i | input | R | Second ciphertext half |
| done_o | output | 1 | One-cycle completion pulse |
| ok_o | output | 1 | 1 = syndrome reached zero, 0 = decoding failure |
| pt_o | output | R | Decoded x0 (plaintext), valid with done_o |

## Verification
The bench aims at the threshold boundary, using two extra instances with uniform thresholds of 4 and 5 and a single error whose count is exactly 5. A design that flips on equality, or never flips, would either fail the decode it should fix or fix the one it should fail. Exact latency checks for a clean ciphertext, a one-pass fix and a full failure catch designs that skip the zero test, exit in mid-pass, or miscount passes. A codeword input and a stray start pulse during a run catch a wrong rotation direction and a design that restarts when it should not. The table cases compare against an independent bit-serial model, which exposes counts taken from a stale syndrome.

// File: rtl/qcmdpc_pkg.sv
package qcmdpc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SYN,
      ST_ZCHK,
      ST_FLIP,
      ST_DONE
   } dec_state_e;
endpackage

// File: rtl/qcmdpc_popcnt.sv
module qcmdpc_popcnt #(
   parameter int W  = 24,
   parameter int CW = $clog2(W + 1)
) (
   input  logic          clk,
   input  logic [W-1:0]  vec_i,
   output logic [CW-1:0] cnt_o
);
   localparam int NC = (W + 5) / 6;

   logic [NC*6-1:0] pad;
   logic [2:0]      part_q [NC];
   logic [CW-1:0]   sum;

   always_comb begin
      pad = '0;
      pad[W-1:0] = vec_i;
   end

   for (genvar g = 0; g < NC; g++) begin : g_chunk
      always_ff @(posedge clk)
         part_q[g] <= 3'($countones(pad[g*6 +: 6]));
   end

   always_comb begin
      sum = '0;
      for (int i = 0; i < NC; i++)
         sum = sum + CW'(part_q[i]);
   end

   always_ff @(posedge clk)
      cnt_o <= sum;
endmodule

// File: rtl/qcmdpc_zero_tree.sv
module qcmdpc_zero_tree #(
   parameter int W = 24
) (
   input  logic         clk,
   input  logic [W-1:0] vec_i,
   output logic         nz_o
);
   localparam int NG = (W + 35) / 36;

   logic [NG*36-1:0] pad;
   logic [NG-1:0]    grp_q;

   always_comb begin
      pad = '0;
      pad[W-1:0] = vec_i;
   end

   for (genvar g = 0; g < NG; g++) begin : g_grp
      always_ff @(posedge clk)
         grp_q[g] <= |pad[g*36 +: 36];
   end

   always_ff @(posedge clk)
      nz_o <= |grp_q;
endmodule

// File: rtl/qcmdpc_bitflip_dec.sv
module qcmdpc_bitflip_dec
   import qcmdpc_pkg::*;
#(
   parameter int R        = 24,
   parameter int MAX_ITER = 5,
   parameter int TW       = 8,
   parameter logic [MAX_ITER*TW-1:0] THRESH = {8'd2, 8'd2, 8'd2, 8'd3, 8'd3}
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [R-1:0] h0_i,
   input  logic [R-1:0] h1_i,
   input  logic [R-1:0] x0_i,
   input  logic [R-1:0] x1_i,
   output logic         done_o,
   output logic         ok_o,
   output logic [R-1:0] pt_o
);
   localparam int CW = $clog2(R + 1);
   localparam int PW = $clog2(R);
   localparam int IW = $clog2(MAX_ITER + 1);

   if (R < 2) begin : g_bad_r
      $error("R must be at least 2");
   end
   if (MAX_ITER < 1) begin : g_bad_iter
      $error("MAX_ITER must be at least 1");
   end
   if (CW > TW) begin : g_bad_tw
      $error("TW too narrow for the count width");
   end

   dec_state_e    st;
   logic [R-1:0]  h0r, h1r, x0r, x1r, syn;
   logic [PW-1:0] pos;
   logic [1:0]    ph;
   logic [IW-1:0] it;
   logic          ok_q;
   logic [CW-1:0] c0, c1;
   logic          nz;
   logic [TW-1:0] thr;
   logic          f0, f1;
   logic          last_pos;

   qcmdpc_popcnt #(.W(R), .CW(CW)) u_pc0 (.clk(clk), .vec_i(syn & h0r), .cnt_o(c0));
   qcmdpc_popcnt #(.W(R), .CW(CW)) u_pc1 (.clk(clk), .vec_i(syn & h1r), .cnt_o(c1));
   qcmdpc_zero_tree #(.W(R)) u_zt (.clk(clk), .vec_i(syn), .nz_o(nz));

   always_comb begin
      thr = '0;
      for (int i = 0; i < MAX_ITER; i++)
         if (it == IW'(i)) thr = THRESH[i*TW +: TW];
   end

   assign f0       = TW'(c0) > thr;
   assign f1       = TW'(c1) > thr;
   assign last_pos = (pos == PW'(R - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         h0r  <= '0;
         h1r  <= '0;
         x0r  <= '0;
         x1r  <= '0;
         syn  <= '0;
         pos  <= '0;
         ph   <= '0;
         it   <= '0;
         ok_q <= 1'b0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (start) begin
                  h0r  <= h0_i;
                  h1r  <= h1_i;
                  x0r  <= x0_i;
                  x1r  <= x1_i;
                  syn  <= '0;
                  pos  <= '0;
                  ph   <= '0;
                  it   <= '0;
                  ok_q <= 1'b0;
                  st   <= ST_SYN;
               end
            end
            ST_SYN: begin
               syn <= syn ^ (x0r[0] ? h0r : '0) ^ (x1r[0] ? h1r : '0);
               h0r <= {h0r[R-2:0], h0r[R-1]};
               h1r <= {h1r[R-2:0], h1r[R-1]};
               x0r <= {x0r[0], x0r[R-1:1]};
               x1r <= {x1r[0], x1r[R-1:1]};
               if (last_pos) begin
                  pos <= '0;
                  ph  <= '0;
                  st  <= ST_ZCHK;
               end else begin
                  pos <= pos + 1'b1;
               end
            end
            ST_ZCHK: begin
               if (ph == 2'd2) begin
                  ph <= '0;
                  if (!nz) begin
                     ok_q <= 1'b1;
                     st   <= ST_DONE;
                  end else if (it == IW'(MAX_ITER)) begin
                     ok_q <= 1'b0;
                     st   <= ST_DONE;
                  end else begin
                     st <= ST_FLIP;
                  end
               end else begin
                  ph <= ph + 1'b1;
               end
            end
            ST_FLIP: begin
               if (ph == 2'd2) begin
                  syn <= syn ^ (f0 ? h0r : '0) ^ (f1 ? h1r : '0);
                  h0r <= {h0r[R-2:0], h0r[R-1]};
                  h1r <= {h1r[R-2:0], h1r[R-1]};
                  x0r <= {x0r[0] ^ f0, x0r[R-1:1]};
                  x1r <= {x1r[0] ^ f1, x1r[R-1:1]};
                  ph  <= '0;
                  if (last_pos) begin
                     pos <= '0;
                     it  <= it + 1'b1;
                     st  <= ST_ZCHK;
                  end else begin
                     pos <= pos + 1'b1;
                  end
               end else begin
                  ph <= ph + 1'b1;
               end
            end
            ST_DONE: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign done_o = (st == ST_DONE);
   assign ok_o   = ok_q;
   assign pt_o   = x0r;
endmodule

// File: rtl/qcmdpc_bitflip_dec_chk.sv
module qcmdpc_bitflip_dec_chk #(
   parameter int R        = 24,
   parameter int MAX_ITER = 5
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start,
   input logic         done_o,
   input logic         ok_o,
   input logic [R-1:0] syn
);
   logic        running;
   logic [31:0] cyc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running <= 1'b0;
         cyc     <= '0;
      end else if (done_o) begin
         running <= 1'b0;
      end else if (start && !running) begin
         running <= 1'b1;
         cyc     <= 32'd1;
      end else if (running) begin
         cyc <= cyc + 32'd1;
      end
   end

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R9
   min_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (running && cyc >= 32'(R + 3)));

   // R6
   fail_after_all_passes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !ok_o) |-> (cyc >= 32'(R + MAX_ITER * 3 * R)));

   // R3
   ok_means_zero_syn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && ok_o) |-> (syn == '0));
endmodule

bind qcmdpc_bitflip_dec qcmdpc_bitflip_dec_chk #(.R(R), .MAX_ITER(MAX_ITER)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .done_o(done_o), .ok_o(ok_o), .syn(syn));

// File: tb/qcmdpc_bitflip_dec_tb.sv
module qcmdpc_bitflip_dec_tb_top;
   localparam int R = 24;
   localparam logic [R-1:0] H0 = 24'h084109;
   localparam logic [R-1:0] H1 = 24'h410822;
   localparam int THR_DEF [5] = '{3, 3, 2, 2, 2};
   localparam int NV = 8;
   localparam logic [2*R-1:0] VEC [NV] = '{
      {24'h000000, 24'h000000},
      {H1,          H0},
      {24'h000020, 24'h000000},
      {24'h000000, 24'h000200},
      {H1 ^ 24'h001000, H0},
      {24'h010001, 24'h000400},
      {24'h00F000, 24'h0000F0},
      {24'hA5A5A5, 24'h5A5A5A}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic st_main = 1'b0, st_lo = 1'b0, st_hi = 1'b0;
   logic [R-1:0] x0 = '0, x1 = '0;
   logic done_m, ok_m, done_l, ok_l, done_h, ok_h;
   logic [R-1:0] pt_m, pt_l, pt_h;
   int checks = 0, errors = 0, cycles = 0;

   always #10 clk = ~clk;

   qcmdpc_bitflip_dec #(.R(R)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(st_main), .h0_i(H0), .h1_i(H1),
      .x0_i(x0), .x1_i(x1), .done_o(done_m), .ok_o(ok_m), .pt_o(pt_m));
   qcmdpc_bitflip_dec #(.R(R), .THRESH({5{8'd4}})) dut_lo_i (
      .clk(clk), .rst_n(rst_n), .start(st_lo), .h0_i(H0), .h1_i(H1),
      .x0_i(x0), .x1_i(x1), .done_o(done_l), .ok_o(ok_l), .pt_o(pt_l));
   qcmdpc_bitflip_dec #(.R(R), .THRESH({5{8'd5}})) dut_hi_i (
      .clk(clk), .rst_n(rst_n), .start(st_hi), .h0_i(H0), .h1_i(H1),
      .x0_i(x0), .x1_i(x1), .done_o(done_h), .ok_o(ok_h), .pt_o(pt_h));

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: act=%0d cycles exp<=150000", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   function automatic logic [R-1:0] rotl(input logic [R-1:0] h, input int j);
      logic [2*R-1:0] d;
      d = {h, h} >> (R - j);
      return d[R-1:0];
   endfunction

   task automatic model(input logic [R-1:0] a0, input logic [R-1:0] a1,
                        output logic ok, output logic [R-1:0] pt);
      logic [R-1:0] s, y0, y1;
      s = '0; y0 = a0; y1 = a1; ok = 1'b0;
      for (int j = 0; j < R; j++) begin
         if (y0[j]) s ^= rotl(H0, j);
         if (y1[j]) s ^= rotl(H1, j);
      end
      if (s == '0) ok = 1'b1;
      for (int it = 0; it < 5 && !ok; it++) begin
         for (int j = 0; j < R; j++) begin
            int k0, k1;
            k0 = $countones(s & rotl(H0, j));
            k1 = $countones(s & rotl(H1, j));
            if (k0 > THR_DEF[it]) begin y0[j] = ~y0[j]; s ^= rotl(H0, j); end
            if (k1 > THR_DEF[it]) begin y1[j] = ~y1[j]; s ^= rotl(H1, j); end
         end
         if (s == '0) ok = 1'b1;
      end
      pt = y0;
   endtask

   task automatic chk(input logic cond, input string tag, input logic [R-1:0] act,
                      input logic [R-1:0] exp);
      checks++;
      if (!cond) begin
         errors++;
         $display("FAIL %s: act=%h exp=%h", tag, act, exp);
      end
   endtask

   // sel: 0 main, 1 lo, 2 hi. glitch: pulse start again mid-run with other data.
   task automatic run_dec(input int sel, input logic [R-1:0] a0, input logic [R-1:0] a1,
                          input bit glitch, output logic ok, output logic [R-1:0] pt,
                          output int lat);
      logic dn;
      @(negedge clk);
      x0 = a0; x1 = a1;
      case (sel) 0: st_main = 1'b1; 1: st_lo = 1'b1; default: st_hi = 1'b1; endcase
      @(negedge clk);
      st_main = 1'b0; st_lo = 1'b0; st_hi = 1'b0;
      lat = 0; dn = 1'b0;
      while (!dn && lat < 3000) begin
         @(negedge clk);
         lat++;
         if (glitch && lat == 10) begin
            x0 = ~a0; x1 = a0 ^ a1;
            st_main = 1'b1;
         end else if (glitch && lat == 11) begin
            st_main = 1'b0;
         end
         case (sel)
            0: begin dn = done_m; ok = ok_m; pt = pt_m; end
            1: begin dn = done_l; ok = ok_l; pt = pt_l; end
            default: begin dn = done_h; ok = ok_h; pt = pt_h; end
         endcase
      end
      chk(dn, "R7 done seen", R'(lat), '0);
      @(negedge clk);
      case (sel)
         0: dn = done_m;
         1: dn = done_l;
         default: dn = done_h;
      endcase
      chk(!dn, "R7 done one cycle", R'(dn), '0);
   endtask

   initial begin
      logic ok, eok;
      logic [R-1:0] pt, ept;
      int lat;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!done_m && !ok_m && pt_m == '0, "R1 reset outputs", pt_m, '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!done_m, "R1 idle no done", R'(done_m), '0);

      // R2 model sanity on a codeword
      model(H1, H0, eok, ept);
      chk(eok && ept == H1, "R2 model codeword", ept, H1);

      // table walk against model: R2 R4 R5
      for (int v = 0; v < NV; v++) begin
         model(VEC[v][2*R-1:R], VEC[v][R-1:0], eok, ept);
         run_dec(0, VEC[v][2*R-1:R], VEC[v][R-1:0], 1'b0, ok, pt, lat);
         chk(ok == eok, "R5 table ok flag", R'(ok), R'(eok));
         chk(pt == ept, "R4 table plaintext", pt, ept);
      end

      // R3 R9 clean ciphertext: no pass, exact latency
      run_dec(0, '0, '0, 1'b0, ok, pt, lat);
      chk(ok && pt == '0, "R3 zero ciphertext", pt, '0);
      chk(lat == R + 3, "R9 latency no pass", R'(lat), R'(R + 3));

      // R2 codeword passes through unchanged
      run_dec(0, H1, H0, 1'b0, ok, pt, lat);
      chk(ok && pt == H1, "R2 codeword unchanged", pt, H1);

      // R4 count 5 > 4 flips: one pass fix
      run_dec(1, 24'h000080, '0, 1'b0, ok, pt, lat);
      chk(ok && pt == '0, "R4 flip above threshold", pt, '0);
      chk(lat == 4 * R + 6, "R9 latency one pass", R'(lat), R'(4 * R + 6));
      run_dec(1, H1, H0 ^ 24'h002000, 1'b0, ok, pt, lat);
      chk(ok && pt == H1, "R4 x1 error fixed", pt, H1);

      // R4 R6 count 5 == 5 never flips: failure after all passes
      run_dec(2, 24'h000080, '0, 1'b0, ok, pt, lat);
      chk(!ok, "R6 failure flag", R'(ok), '0);
      chk(pt == 24'h000080, "R4 equal count no flip", pt, 24'h000080);
      chk(lat == R + 3 + 5 * (3 * R + 3), "R6 latency full fail", R'(lat),
          R'(R + 3 + 5 * (3 * R + 3)));

      // R8 stray start during run is ignored
      model(VEC[6][2*R-1:R], VEC[6][R-1:0], eok, ept);
      run_dec(0, VEC[6][2*R-1:R], VEC[6][R-1:0], 1'b1, ok, pt, lat);
      chk(ok == eok && pt == ept, "R8 start ignored", pt, ept);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule